// File: doc/BRIEF.md
# Performance Monitor Condition Event Unit

This unit watches a free-running 64-bit time base and a bank of performance counters. It turns two kinds of condition into action requests. The first is a rising edge on one time-base bit picked by a 2-bit tap selector. The second is a counter turning negative. The counters, the sources that feed them and the exception handler sit outside the unit. The unit only detects the conditions and routes them.

Every condition is reduced to a single event each cycle. That event goes to three registered one-cycle request outputs: freeze the counters, trigger the counters, and raise an exception. Each output has its own action enable. The first counter has a negative-condition enable of its own, and all the other counters share one enable. The history of the selected time-base bit is refreshed every cycle from whichever bit is selected at that moment. Software that changes the tap while time-base events are enabled can therefore see an immediate spurious event. That behaviour is intended and is checked.

Top module: `pmon_cond_unit`

## Requirements
- R1: A synchronous active-high reset drives all three request outputs to 0 and clears all edge history to 0. An input bit that is already 1 at the first clock after reset is therefore seen as a rising edge.
- R2: The tap selector picks the time-base bit, counting bit 0 as the least significant bit: 0 selects bit 0, 1 selects bit 8, 2 selects bit 12, 3 selects bit 16. A rising edge on any bit that is not selected causes no request.
- R3: A time-base event happens only when the selected bit is 1 now and was 0 in the previous cycle, and only while the time-base event enable is 1. A falling edge or a steady level causes nothing.
- R4: The previous-bit register samples the bit selected at that moment. Changing the selector from a tap reading 0 to a tap reading 1 while the time-base event enable is 1 produces a request at once.
- R5: Counter 0 is negative when its most significant bit is 1. Its negative condition raises an event only while the counter-0 condition enable is 1.
- R6: A negative condition on any counter other than counter 0 raises an event only while the shared other-counter condition enable is 1.
- R7: Negative conditions are edge-detected. An event fires once when a counter's most significant bit goes from 0 to 1, and does not fire again while the bit stays at 1.
- R8: The freeze, trigger and exception requests are each gated by their own action enable, sampled in the same cycle as the condition.
- R9: Conditions that occur in the same cycle are OR-combined into one event. All three outputs reflect that shared event, and each pulse lasts exactly one cycle.
- R10: The outputs are registered. A condition present on the inputs before a clock edge appears on the outputs after that edge, and does not appear earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_value | input | 64 | Time-base value, bit 0 least significant |
| ctr_values | input | NUM_CTR*CTR_W | Counter values, counter i at bits [i*CTR_W +: CTR_W] |
| tb_sel | input | 2 | Time-base tap selector |
| tb_evt_en | input | 1 | Time-base event enable |
| ctr0_cond_en | input | 1 | Negative-condition enable for counter 0 |
| ctrn_cond_en | input | 1 | Shared negative-condition enable for the other counters |
| act_freeze_en | input | 1 | Enable for the freeze request |
| act_trigger_en | input | 1 | Enable for the trigger request |
| act_except_en | input | 1 | Enable for the exception request |
| freeze_req | output | 1 | One-cycle freeze request |
| trigger_req | output | 1 | One-cycle trigger request |
| except_req | output | 1 | One-cycle exception request |

## Verification
A stale or wrongly loaded history bit shows at the ports as a missing request, a request that repeats, or a request with no cause. Any of these appears in the output cycle that directly follows the first edge the history compares against. A wrong tap index shows up as silence on the intended bit and a pulse from a neighbouring bit, one cycle after that bit rises. A wrong gate or a wrong merge shows as a mismatch among the three outputs in that same cycle.

// File: rtl/pmon_cond_pkg.sv
package pmon_cond_pkg;
  localparam int TB_W = 64;

  // tap positions counted from the least significant bit
  localparam int TAP_IDX0 = 0;
  localparam int TAP_IDX1 = 8;
  localparam int TAP_IDX2 = 12;
  localparam int TAP_IDX3 = 16;

  typedef enum logic [1:0] {
    TAP_FAST   = 2'd0,
    TAP_MEDIUM = 2'd1,
    TAP_SLOW   = 2'd2,
    TAP_SLOWER = 2'd3
  } tap_sel_e;
endpackage

// File: rtl/pmon_tb_tap.sv
module pmon_tb_tap
  import pmon_cond_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [TB_W-1:0] tb_value,
  input  tap_sel_e        sel,
  input  logic            enable,
  output logic            hit
);
  logic cur_bit;
  logic prev_bit;

  always_comb begin
    unique case (sel)
      TAP_FAST:   cur_bit = tb_value[TAP_IDX0];
      TAP_MEDIUM: cur_bit = tb_value[TAP_IDX1];
      TAP_SLOW:   cur_bit = tb_value[TAP_IDX2];
      default:    cur_bit = tb_value[TAP_IDX3];
    endcase
  end

  // history follows whatever tap is selected now (R4 spurious edge)
  always_ff @(posedge clk) begin
    if (rst) prev_bit <= 1'b0;
    else     prev_bit <= cur_bit;
  end

  assign hit = enable & cur_bit & ~prev_bit;
endmodule

// File: rtl/pmon_neg_watch.sv
module pmon_neg_watch #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CTR*CTR_W-1:0] ctr_values,
  input  logic                     en_first,
  input  logic                     en_rest,
  output logic                     hit
);
  logic [NUM_CTR-1:0] sign_now;
  logic [NUM_CTR-1:0] sign_prev;
  logic [NUM_CTR-1:0] gate;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign sign_now[i] = ctr_values[i*CTR_W + CTR_W - 1];
    if (i == 0) begin : g_first
      assign gate[i] = en_first;
    end else begin : g_rest
      assign gate[i] = en_rest;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sign_prev <= '0;
    else     sign_prev <= sign_now;
  end

  assign hit = |(gate & sign_now & ~sign_prev);
endmodule

// File: rtl/pmon_action_route.sv
module pmon_action_route #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic               freeze_en,
  input  logic               trigger_en,
  input  logic               except_en,
  output logic               freeze_req,
  output logic               trigger_req,
  output logic               except_req
);
  logic any_evt;
  assign any_evt = |src;

  always_ff @(posedge clk) begin
    if (rst) begin
      freeze_req  <= 1'b0;
      trigger_req <= 1'b0;
      except_req  <= 1'b0;
    end else begin
      freeze_req  <= any_evt & freeze_en;
      trigger_req <= any_evt & trigger_en;
      except_req  <= any_evt & except_en;
    end
  end
endmodule

// File: rtl/pmon_cond_unit.sv
module pmon_cond_unit
  import pmon_cond_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [TB_W-1:0]          tb_value,
  input  logic [NUM_CTR*CTR_W-1:0] ctr_values,
  input  logic [1:0]               tb_sel,
  input  logic                     tb_evt_en,
  input  logic                     ctr0_cond_en,
  input  logic                     ctrn_cond_en,
  input  logic                     act_freeze_en,
  input  logic                     act_trigger_en,
  input  logic                     act_except_en,
  output logic                     freeze_req,
  output logic                     trigger_req,
  output logic                     except_req
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0] src;

  pmon_tb_tap u_tap (
    .clk      (clk),
    .rst      (rst),
    .tb_value (tb_value),
    .sel      (tap_sel_e'(tb_sel)),
    .enable   (tb_evt_en),
    .hit      (src[0])
  );

  pmon_neg_watch #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_neg (
    .clk        (clk),
    .rst        (rst),
    .ctr_values (ctr_values),
    .en_first   (ctr0_cond_en),
    .en_rest    (ctrn_cond_en),
    .hit        (src[1])
  );

  pmon_action_route #(.NUM_SRC(NUM_SRC)) u_route (
    .clk         (clk),
    .rst         (rst),
    .src         (src),
    .freeze_en   (act_freeze_en),
    .trigger_en  (act_trigger_en),
    .except_en   (act_except_en),
    .freeze_req  (freeze_req),
    .trigger_req (trigger_req),
    .except_req  (except_req)
  );
endmodule

// File: rtl/pmon_cond_chk.sv
module pmon_cond_chk
  import pmon_cond_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [TB_W-1:0] tb_value,
  input logic [1:0]      tb_sel,
  input logic            tb_evt_en,
  input logic            ctr0_cond_en,
  input logic            ctrn_cond_en,
  input logic            act_freeze_en,
  input logic            act_trigger_en,
  input logic            act_except_en,
  input logic            freeze_req,
  input logic            trigger_req,
  input logic            except_req
);
  logic tap_bit;
  always_comb begin
    case (tb_sel)
      2'd0:    tap_bit = tb_value[TAP_IDX0];
      2'd1:    tap_bit = tb_value[TAP_IDX1];
      2'd2:    tap_bit = tb_value[TAP_IDX2];
      default: tap_bit = tb_value[TAP_IDX3];
    endcase
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!freeze_req && !trigger_req && !except_req));

  p_tb_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (freeze_req && !$past(ctr0_cond_en) && !$past(ctrn_cond_en))
      |-> ($past(tb_evt_en) && $past(tap_bit)));

  p_some_source_r5: assert property (@(posedge clk) disable iff (rst)
    (freeze_req || trigger_req || except_req)
      |-> $past(tb_evt_en || ctr0_cond_en || ctrn_cond_en));

  p_freeze_gate_r8: assert property (@(posedge clk) disable iff (rst)
    freeze_req |-> $past(act_freeze_en));

  p_trigger_gate_r8: assert property (@(posedge clk) disable iff (rst)
    trigger_req |-> $past(act_trigger_en));

  p_except_gate_r8: assert property (@(posedge clk) disable iff (rst)
    except_req |-> $past(act_except_en));

  p_shared_event_r9: assert property (@(posedge clk) disable iff (rst)
    (freeze_req && $past(act_trigger_en)) |-> trigger_req);
endmodule

bind pmon_cond_unit pmon_cond_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .tb_value       (tb_value),
  .tb_sel         (tb_sel),
  .tb_evt_en      (tb_evt_en),
  .ctr0_cond_en   (ctr0_cond_en),
  .ctrn_cond_en   (ctrn_cond_en),
  .act_freeze_en  (act_freeze_en),
  .act_trigger_en (act_trigger_en),
  .act_except_en  (act_except_en),
  .freeze_req     (freeze_req),
  .trigger_req    (trigger_req),
  .except_req     (except_req)
);

// File: tb/pmon_cond_unit_tb.sv
module pmon_cond_unit_tb;
  localparam int NUM_CTR = 4;
  localparam int CTR_W   = 32;

  logic                     clk = 1'b0;
  logic                     rst;
  logic [63:0]              tb_value;
  logic [NUM_CTR*CTR_W-1:0] ctr_values;
  logic [1:0]               tb_sel;
  logic                     tb_evt_en, ctr0_cond_en, ctrn_cond_en;
  logic                     act_freeze_en, act_trigger_en, act_except_en;
  logic                     freeze_req, trigger_req, except_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pmon_cond_unit #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_dut (
    .clk(clk), .rst(rst), .tb_value(tb_value), .ctr_values(ctr_values),
    .tb_sel(tb_sel), .tb_evt_en(tb_evt_en), .ctr0_cond_en(ctr0_cond_en),
    .ctrn_cond_en(ctrn_cond_en), .act_freeze_en(act_freeze_en),
    .act_trigger_en(act_trigger_en), .act_except_en(act_except_en),
    .freeze_req(freeze_req), .trigger_req(trigger_req), .except_req(except_req)
  );

  function automatic int tap_pos(int s);
    case (s)
      0: return 0;
      1: return 8;
      2: return 12;
      default: return 16;
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic ef, logic et, logic ex);
    total++;
    if (freeze_req !== ef || trigger_req !== et || except_req !== ex) begin
      bad++;
      $display("FAIL %s: got f/t/x=%b%b%b expected %b%b%b",
               req, freeze_req, trigger_req, except_req, ef, et, ex);
    end
  endtask

  task automatic quiet();
    tb_value = '0; ctr_values = '0;
    tick(); tick();
  endtask

  task automatic set_ctr_msb(int i, logic v);
    ctr_values[i*CTR_W + CTR_W - 1] = v;
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tb_sel = 2'd0;
    tb_value = '1; ctr_values = '1;
    tb_evt_en = 1; ctr0_cond_en = 1; ctrn_cond_en = 1;
    act_freeze_en = 1; act_trigger_en = 1; act_except_en = 1;
    tick(); tick();
    chk("R1 outputs cleared in reset", 0, 0, 0);
    rst = 1'b0;
    tick();
    chk("R1 history cleared, high inputs seen as edge", 1, 1, 1);
    tick();
    chk("R9 single pulse after reset edge", 0, 0, 0);

    // time-base taps
    ctr0_cond_en = 0; ctrn_cond_en = 0;
    for (int s = 0; s < 4; s++) begin
      tb_sel = 2'(s);
      quiet();
      tb_value[tap_pos((s + 1) % 4)] = 1'b1;
      tb_value[tap_pos(s) + 1] = 1'b1;
      tick();
      chk("R2 unselected bit ignored", 0, 0, 0);
      tb_value[tap_pos(s)] = 1'b1;
      chk("R10 no output before edge", 0, 0, 0);
      tick();
      chk("R2 selected bit rise fires", 1, 1, 1);
      tick();
      chk("R3 steady high no repeat", 0, 0, 0);
      tb_value[tap_pos(s)] = 1'b0;
      tick();
      chk("R3 falling edge ignored", 0, 0, 0);
      tb_evt_en = 0;
      tb_value[tap_pos(s)] = 1'b1;
      tick();
      chk("R3 disabled rise ignored", 0, 0, 0);
      tb_evt_en = 1;
    end

    // spurious edge on tap change
    for (int en = 0; en < 2; en++) begin
      tb_evt_en = 1'(en);
      tb_sel = 2'd0;
      tb_value = '0; tb_value[tap_pos(1)] = 1'b1;
      tick(); tick();
      chk("R4 settled on low tap", 0, 0, 0);
      tb_sel = 2'd1;
      tick();
      chk("R4 tap change false edge", 1'(en), 1'(en), 1'(en));
      tick();
      chk("R4 false edge one pulse", 0, 0, 0);
    end

    // counters
    tb_evt_en = 0;
    for (int i = 0; i < NUM_CTR; i++) begin
      for (int c = 0; c < 4; c++) begin
        logic e;
        ctr0_cond_en = c[0]; ctrn_cond_en = c[1];
        e = (i == 0) ? c[0] : c[1];
        quiet();
        set_ctr_msb(i, 1'b1);
        tick();
        if (i == 0) chk("R5 counter0 negative", e, e, e);
        else        chk("R6 other counter negative", e, e, e);
        tick();
        chk("R7 stays negative no repeat", 0, 0, 0);
      end
    end

    // action gating
    ctr0_cond_en = 0; ctrn_cond_en = 0; tb_evt_en = 1; tb_sel = 2'd2;
    for (int a = 0; a < 8; a++) begin
      act_freeze_en = a[0]; act_trigger_en = a[1]; act_except_en = a[2];
      quiet();
      tb_value[tap_pos(2)] = 1'b1;
      tick();
      chk("R8 per-action gate", a[0], a[1], a[2]);
    end

    // simultaneous sources
    act_freeze_en = 1; act_trigger_en = 1; act_except_en = 1;
    ctr0_cond_en = 1; ctrn_cond_en = 1;
    quiet();
    tb_value[tap_pos(2)] = 1'b1;
    set_ctr_msb(0, 1'b1); set_ctr_msb(3, 1'b1);
    tick();
    chk("R9 merged sources fire", 1, 1, 1);
    tick();
    chk("R9 merged sources one pulse", 0, 0, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule